// File: doc/BRIEF.md
# Channel Enable and Group Controller

This block keeps one enable bit for each channel of an event routing fabric. Software can write the whole enable vector at once, or change selected bits through a write-1-to-set register and a write-1-to-clear register. Bits can also be changed in bulk through channel groups. Each group has a programmable membership mask. A group enable task turns on every channel in that mask, and a group disable task turns them off.

A group task is a single-cycle pulse. It can come from a register write on the simple bus, or from a per-group pulse input driven by the routing fabric's task outputs. All sources that act in the same cycle are combined in one update. Any source that sets a bit overrides any source that clears the same bit, so a channel hit by both an enable and a disable ends up enabled.

The bus has no wait states. A write takes effect at the next clock edge. Read data is combinational and reflects the address presented in the same cycle.

Top module: `chen_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every channel enable bit and every group membership mask reads 0.
- R2: A write to byte address 0x500 loads the enable vector with the write data. A read of 0x500, 0x504 or 0x508 returns the current enable vector.
- R3: A write to 0x504 sets every enable bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A write to 0x508 clears every enable bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: The membership mask of group g (g = 0..5) is written and read at byte address 0x800 + 4·g.
- R6: A write to 0x000 + 8·g triggers the enable task of group g, and a write to 0x004 + 8·g triggers its disable task. The write data is ignored. An enable task sets the enable bits selected by the group's mask; a disable task clears them.
- R7: A pulse on hw_grp_en[g] or hw_grp_dis[g] has the same effect as the matching task write.
- R8: In one cycle the next vector is (current & ~clears) | sets. So an enable beats a disable on the same channel, whether the two come from one group or from different groups. A group enable also beats a register clear.
- R9: A channel may belong to several groups. Each group task acts on every channel of its own mask, and a group task uses the mask value held before any same-cycle mask write.
- R10: Writes to unmapped addresses change nothing, reads of them return 0. This covers task addresses at or above 0x030 and mask addresses at or above 0x818.
- R11: In a cycle with no bus write and no task pulse, the enable vector holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| hw_grp_en | input | 6 | Per-group enable task pulses from the fabric |
| hw_grp_dis | input | 6 | Per-group disable task pulses from the fabric |
| ch_en | output | 32 | Channel enable vector |

## Verification
The assertions check on every cycle the rules that depend only on what happens in that cycle:
- the set, clear and full-write effects;
- that the selected mask bits end up on after any fabric enable pulse;
- that the mask bits end up cleared after an uncontested fabric disable;
- that the vector holds when nothing happens.

Only the bench scenarios can show the following:
- the mask readback and address decode, including the unmapped task and mask slots;
- that the task write data is ignored;
- that a task uses the old mask during a same-cycle mask write;
- the mixed collisions between a register task from the bus and a fabric pulse of another group.

// File: rtl/chen_pkg.sv
package chen_pkg;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_CHAN,
        RD_MASK
    } rd_src_e;

    localparam int unsigned OFS_CH_WR     = 'h500;
    localparam int unsigned OFS_CH_SET    = 'h504;
    localparam int unsigned OFS_CH_CLR    = 'h508;
    localparam int unsigned OFS_MASK_BASE = 'h800;

endpackage

// File: rtl/chen_bus_decode.sv
module chen_bus_decode
    import chen_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int NUM_GRP = 6
) (
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    output logic               wr_full,
    output logic               wr_set,
    output logic               wr_clr,
    output logic [NUM_GRP-1:0] sw_en,
    output logic [NUM_GRP-1:0] sw_dis,
    output logic [NUM_GRP-1:0] mask_we,
    output rd_src_e            rd_src,
    output logic [ADDR_W-3:0]  rd_grp
);

    localparam logic [ADDR_W-1:0] TASK_END  = ADDR_W'(NUM_GRP * 8);
    localparam logic [ADDR_W-1:0] MASK_LO   = ADDR_W'(OFS_MASK_BASE);
    localparam logic [ADDR_W-1:0] MASK_HI   = ADDR_W'(OFS_MASK_BASE + NUM_GRP * 4);

    logic               acc_wr;
    logic               aligned;
    logic               in_task;
    logic               in_mask;
    logic               at_chan;
    logic [ADDR_W-1:0]  mask_off;
    logic [ADDR_W-4:0]  task_grp;
    logic [ADDR_W-3:0]  mask_grp;

    always_comb begin
        acc_wr   = bus_valid && bus_write;
        aligned  = (bus_addr[1:0] == 2'b00);
        in_task  = aligned && (bus_addr < TASK_END);
        in_mask  = aligned && (bus_addr >= MASK_LO) && (bus_addr < MASK_HI);
        mask_off = bus_addr - MASK_LO;
        task_grp = bus_addr[ADDR_W-1:3];
        mask_grp = mask_off[ADDR_W-1:2];
        at_chan  = (bus_addr == ADDR_W'(OFS_CH_WR)) ||
                   (bus_addr == ADDR_W'(OFS_CH_SET)) ||
                   (bus_addr == ADDR_W'(OFS_CH_CLR));
        wr_full  = acc_wr && (bus_addr == ADDR_W'(OFS_CH_WR));
        wr_set   = acc_wr && (bus_addr == ADDR_W'(OFS_CH_SET));
        wr_clr   = acc_wr && (bus_addr == ADDR_W'(OFS_CH_CLR));
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp_dec
        assign sw_en[g]   = acc_wr && in_task && !bus_addr[2] && (task_grp == (ADDR_W-3)'(g));
        assign sw_dis[g]  = acc_wr && in_task &&  bus_addr[2] && (task_grp == (ADDR_W-3)'(g));
        assign mask_we[g] = acc_wr && in_mask && (mask_grp == (ADDR_W-2)'(g));
    end

    always_comb begin
        rd_grp = mask_grp;
        if (!bus_valid || bus_write) begin
            rd_src = RD_NONE;
        end else if (at_chan) begin
            rd_src = RD_CHAN;
        end else if (in_mask) begin
            rd_src = RD_MASK;
        end else begin
            rd_src = RD_NONE;
        end
    end

endmodule

// File: rtl/chen_group_regs.sv
module chen_group_regs #(
    parameter int NUM_CH  = 32,
    parameter int NUM_GRP = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_GRP-1:0]              mask_we,
    input  logic [NUM_CH-1:0]               wdata,
    output logic [NUM_GRP-1:0][NUM_CH-1:0]  masks
);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                masks[g] <= '0;
            end else if (mask_we[g]) begin
                masks[g] <= wdata;
            end
        end
    end

endmodule

// File: rtl/chen_update.sv
module chen_update #(
    parameter int NUM_CH  = 32,
    parameter int NUM_GRP = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_full,
    input  logic                            wr_set,
    input  logic                            wr_clr,
    input  logic [NUM_CH-1:0]               wdata,
    input  logic [NUM_GRP-1:0]              grp_en,
    input  logic [NUM_GRP-1:0]              grp_dis,
    input  logic [NUM_GRP-1:0][NUM_CH-1:0]  masks,
    output logic [NUM_CH-1:0]               ch_q
);

    logic [NUM_CH-1:0] set_v;
    logic [NUM_CH-1:0] clr_v;
    logic [NUM_CH-1:0] nxt;

    always_comb begin
        set_v = '0;
        clr_v = '0;
        if (wr_full) begin
            set_v = set_v | wdata;
            clr_v = clr_v | ~wdata;
        end
        if (wr_set) set_v = set_v | wdata;
        if (wr_clr) clr_v = clr_v | wdata;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (grp_en[g])  set_v = set_v | masks[g];
            if (grp_dis[g]) clr_v = clr_v | masks[g];
        end
        nxt = (ch_q & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q <= '0;
        end else begin
            ch_q <= nxt;
        end
    end

endmodule

// File: rtl/chen_ctrl.sv
module chen_ctrl
    import chen_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int NUM_GRP = 6,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NUM_CH-1:0]  bus_wdata,
    output logic [NUM_CH-1:0]  bus_rdata,
    input  logic [NUM_GRP-1:0] hw_grp_en,
    input  logic [NUM_GRP-1:0] hw_grp_dis,
    output logic [NUM_CH-1:0]  ch_en
);

    logic                            wr_full;
    logic                            wr_set;
    logic                            wr_clr;
    logic [NUM_GRP-1:0]              sw_en;
    logic [NUM_GRP-1:0]              sw_dis;
    logic [NUM_GRP-1:0]              mask_we;
    rd_src_e                         rd_src;
    logic [ADDR_W-3:0]               rd_grp;
    logic [NUM_GRP-1:0][NUM_CH-1:0]  grp_mask;
    logic [NUM_CH-1:0]               ch_q;
    logic [NUM_CH-1:0]               mask_rd;

    chen_bus_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_GRP (NUM_GRP)
    ) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .wr_full   (wr_full),
        .wr_set    (wr_set),
        .wr_clr    (wr_clr),
        .sw_en     (sw_en),
        .sw_dis    (sw_dis),
        .mask_we   (mask_we),
        .rd_src    (rd_src),
        .rd_grp    (rd_grp)
    );

    chen_group_regs #(
        .NUM_CH  (NUM_CH),
        .NUM_GRP (NUM_GRP)
    ) u_grp (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (mask_we),
        .wdata   (bus_wdata),
        .masks   (grp_mask)
    );

    chen_update #(
        .NUM_CH  (NUM_CH),
        .NUM_GRP (NUM_GRP)
    ) u_upd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_full (wr_full),
        .wr_set  (wr_set),
        .wr_clr  (wr_clr),
        .wdata   (bus_wdata),
        .grp_en  (sw_en | hw_grp_en),
        .grp_dis (sw_dis | hw_grp_dis),
        .masks   (grp_mask),
        .ch_q    (ch_q)
    );

    always_comb begin
        mask_rd = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (rd_grp == (ADDR_W-2)'(g)) mask_rd = grp_mask[g];
        end
    end

    always_comb begin
        unique case (rd_src)
            RD_CHAN: bus_rdata = ch_q;
            RD_MASK: bus_rdata = mask_rd;
            default: bus_rdata = '0;
        endcase
    end

    assign ch_en = ch_q;

endmodule

// File: rtl/chen_checker.sv
module chen_checker
    import chen_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int NUM_GRP = 6,
    parameter int ADDR_W  = 12
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            bus_valid,
    input logic                            bus_write,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic [NUM_CH-1:0]               bus_wdata,
    input logic [NUM_GRP-1:0]              hw_grp_en,
    input logic [NUM_GRP-1:0]              hw_grp_dis,
    input logic [NUM_CH-1:0]               ch_en,
    input logic [NUM_GRP-1:0][NUM_CH-1:0]  masks
);

    logic bw;
    logic no_hw;
    assign bw    = bus_valid && bus_write;
    assign no_hw = (hw_grp_en == '0) && (hw_grp_dis == '0);

    AST_FULL_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (bw && bus_addr == ADDR_W'(OFS_CH_WR) && no_hw) |=> (ch_en == $past(bus_wdata))); // R2

    AST_SET_REG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (bw && bus_addr == ADDR_W'(OFS_CH_SET)) |=> ((ch_en & $past(bus_wdata)) == $past(bus_wdata))); // R3

    AST_CLR_REG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bw && bus_addr == ADDR_W'(OFS_CH_CLR) && hw_grp_en == '0) |=> ((ch_en & $past(bus_wdata)) == '0)); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bw && no_hw) |=> $stable(ch_en)); // R11

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
        AST_GRP_EN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            hw_grp_en[g] |=> ((ch_en & $past(masks[g])) == $past(masks[g]))); // R8

        AST_GRP_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (hw_grp_dis[g] && !bw && hw_grp_en == '0) |=> ((ch_en & $past(masks[g])) == '0)); // R7
    end

endmodule

bind chen_ctrl chen_checker #(
    .NUM_CH  (NUM_CH),
    .NUM_GRP (NUM_GRP),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .hw_grp_en  (hw_grp_en),
    .hw_grp_dis (hw_grp_dis),
    .ch_en      (ch_en),
    .masks      (grp_mask)
);

// File: tb/chen_ctrl_bench.sv
module chen_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 32;
    localparam int NG  = 6;
    localparam int AW  = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_valid = 1'b0;
    logic           bus_write = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [NCH-1:0] bus_wdata = '0;
    logic [NCH-1:0] bus_rdata;
    logic [NG-1:0]  hw_grp_en = '0;
    logic [NG-1:0]  hw_grp_dis = '0;
    logic [NCH-1:0] ch_en;

    chen_ctrl u_chen_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .hw_grp_en  (hw_grp_en),
        .hw_grp_dis (hw_grp_dis),
        .ch_en      (ch_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [NCH-1:0] exp;
        string          tag;
    } sb_item_t;

    sb_item_t       sb_q[$];
    int             n_run  = 0;
    int             n_fail = 0;
    logic [NCH-1:0] m_en = '0;
    logic [NCH-1:0] m_mask [NG];
    bit             done = 0;

    task automatic check(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] model_read(input logic [AW-1:0] a);
        if (a == 12'h500 || a == 12'h504 || a == 12'h508) return m_en;
        for (int g = 0; g < NG; g++) begin
            if (a == AW'(12'h800 + 4*g)) return m_mask[g];
        end
        return '0;
    endfunction

    // Drive one cycle; the expected vector is pushed after the edge
    // and compared by the monitor at the following falling edge.
    task automatic step(input logic v, input logic w, input logic [AW-1:0] a,
                        input logic [NCH-1:0] d, input logic [NG-1:0] he,
                        input logic [NG-1:0] hd, input string tag);
        logic [NCH-1:0] sets;
        logic [NCH-1:0] clrs;
        sb_item_t       it;
        @(negedge clk);
        bus_valid  = v;
        bus_write  = w;
        bus_addr   = a;
        bus_wdata  = d;
        hw_grp_en  = he;
        hw_grp_dis = hd;
        #1;
        if (v && !w) check({tag, " read"}, bus_rdata, model_read(a));
        sets = '0;
        clrs = '0;
        if (v && w) begin
            if (a == 12'h500) begin sets |= d; clrs |= ~d; end
            if (a == 12'h504) sets |= d;
            if (a == 12'h508) clrs |= d;
        end
        for (int g = 0; g < NG; g++) begin
            if (he[g] || (v && w && a == AW'(8*g)))     sets |= m_mask[g];
            if (hd[g] || (v && w && a == AW'(8*g + 4))) clrs |= m_mask[g];
        end
        @(posedge clk);
        m_en = (m_en & ~clrs) | sets;
        if (v && w) begin
            for (int g = 0; g < NG; g++) begin
                if (a == AW'(12'h800 + 4*g)) m_mask[g] = d;
            end
        end
        it.exp = m_en;
        it.tag = tag;
        sb_q.push_back(it);
        #1;
        bus_valid  = 1'b0;
        bus_write  = 1'b0;
        hw_grp_en  = '0;
        hw_grp_dis = '0;
    endtask

    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            check(it.tag, ch_en, it.exp);
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [NCH-1:0] d, input string tag);
        step(1'b1, 1'b1, a, d, '0, '0, tag);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        step(1'b1, 1'b0, a, '0, '0, '0, tag);
    endtask

    task automatic hw(input logic [NG-1:0] he, input logic [NG-1:0] hd, input string tag);
        step(1'b0, 1'b0, '0, '0, he, hd, tag);
    endtask

    initial begin
        for (int g = 0; g < NG; g++) m_mask[g] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset vector", ch_en, '0);
        rd(12'h800, "R1 reset mask0");
        rd(12'h814, "R1 reset mask5");

        wr(12'h500, 32'hA5A5_0F0F, "R2 full write");
        rd(12'h500, "R2 read wr addr");
        rd(12'h504, "R2 read set addr");
        rd(12'h508, "R2 read clr addr");
        wr(12'h504, 32'h0000_00F0, "R3 set mask");
        wr(12'h508, 32'h0F00_000F, "R4 clear mask");
        rd(12'h500, "R4 readback");

        wr(12'h800, 32'h0000_FFFF, "R5 mask0 write");
        wr(12'h804, 32'h00FF_0000, "R5 mask1 write");
        wr(12'h808, 32'hF000_000F, "R5 mask2 write");
        wr(12'h814, 32'h8000_0001, "R5 mask5 write");
        rd(12'h804, "R5 mask1 read");
        rd(12'h814, "R5 mask5 read");

        wr(12'h500, 32'h0, "R2 zero vector");
        wr(12'h000, 32'hDEAD_0000, "R6 sw enable g0");
        wr(12'h004, 32'h0, "R6 sw disable g0");
        wr(12'h028, 32'h1234_5678, "R6 sw enable g5");
        wr(12'h02C, 32'hFFFF_FFFF, "R6 sw disable g5");

        hw(6'b000010, 6'b000000, "R7 hw enable g1");
        hw(6'b000000, 6'b000010, "R7 hw disable g1");
        hw(6'b000101, 6'b000000, "R9 hw enable g0 g2 overlap");
        hw(6'b000000, 6'b000100, "R9 hw disable g2 shared bits");
        hw(6'b000100, 6'b000100, "R8 same group en and dis");
        hw(6'b000001, 6'b000100, "R8 en g0 dis g2");
        step(1'b1, 1'b1, 12'h508, 32'hFFFF_FFFF, 6'b000010, '0, "R8 clear reg vs hw enable g1");
        step(1'b1, 1'b1, 12'h004, 32'h0, 6'b000100, '0, "R8 sw disable g0 vs hw enable g2");

        step(1'b1, 1'b1, 12'h800, 32'h00F0_0000, 6'b000001, '0, "R9 old mask used");
        rd(12'h800, "R9 new mask visible");
        hw(6'b000001, 6'b000000, "R9 new mask in effect");

        wr(12'h100, 32'hFFFF_FFFF, "R10 unmapped write");
        rd(12'h100, "R10 unmapped read");
        wr(12'h818, 32'hFFFF_FFFF, "R10 mask slot 6 write");
        rd(12'h818, "R10 mask slot 6 read");
        wr(12'h034, 32'h0, "R10 task slot 6 disable");
        wr(12'h501, 32'h0, "R10 unaligned write");

        hw('0, '0, "R11 idle 1");
        rd(12'h504, "R11 read during idle");
        hw('0, '0, "R11 idle 2");

        repeat (3) @(negedge clk);
        check("R11 queue drained", 32'(sb_q.size()), 32'd0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R11 watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule